// File: doc/BRIEF.md
# Dual-Clock FIFO with Push-Side Flush

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. Words enter on the push clock and leave on the pop clock, in the order they were written. Each side keeps its own pointer. The pointers are exchanged as Gray-coded values through two-stage synchronizers. Each side then works out its own fill count from its own pointer and the synchronized copy of the other side's pointer.

The write side can request a flush. The request is a toggle that crosses into the read clock domain. On the first read-clock edge where the toggle is seen, the read side starts a fixed routine of four clock cycles, then clears its read pointer. Completion returns to the write side as a second toggle. During the flush each side lowers its own valid output, and while that output is low its status code must not be trusted.

Both sides report a 4-bit fill code. Below eight entries the code is the exact count. Above that it is coarse: eight or more, a quarter, a half, and full, with the highest matching code winning. The read side also drives an almost-empty indication that rises when a flush completes.

Top module: `xff_fifo`

## Requirements
- R1: Once both resets are released with no traffic: push_flag is 0000, pop_flag is 0000, push_ok is 1, pop_ok is 1 and pop_almost_empty is 1.
- R2: Words leave in the order they were accepted. pop_data takes the next word on the pop_clk edge at which pop_en is sampled high on a non-empty FIFO.
- R3: While pop_ok is high, pop_flag equals the read-side fill count, written as a binary number, whenever that count is 0 to 7.
- R4: Coarse codes apply with this priority: 1111 when 64 entries are held, otherwise 1110 at 32 or more, otherwise 1101 at 16 or more, otherwise 1000 at 8 or more. Codes 1001 to 1100 are never output while the flag is valid.
- R5: push_flag uses the same encoding, taken over the write-side fill count. At 64 entries a push is ignored and nothing is stored.
- R6: A pop when pop_flag is 0000 is ignored: pop_data keeps its value and no pointer moves.
- R7: Outside a flush, pop_almost_empty is 1 when the read-side count is 2 or less and 0 when it is higher.
- R8: push_flush sampled high on a push_clk edge drops push_ok on that edge. Pushes are ignored until push_ok returns.
- R9: The read-side flush routine holds pop_ok low for exactly four pop_clk cycles. During that time pops are ignored (pop_data stable) and pop_almost_empty is 0.
- R10: When the flush completes, pop_ok rises with pop_flag 0000 and pop_almost_empty 1. Later, push_ok rises with push_flag 0000. All earlier content is gone, and new words then flow normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| push_clk | input | 1 | Write-side clock |
| push_rst_n | input | 1 | Write-side asynchronous reset, active low |
| push_en | input | 1 | Write a word this cycle |
| push_data | input | DW | Word to write |
| push_flush | input | 1 | Request a flush of the whole FIFO |
| push_flag | output | 4 | Write-side fill code |
| push_ok | output | 1 | Write-side code valid, low during a flush |
| pop_clk | input | 1 | Read-side clock |
| pop_rst_n | input | 1 | Read-side asynchronous reset, active low |
| pop_en | input | 1 | Read a word this cycle |
| pop_data | output | DW | Last word read |
| pop_flag | output | 4 | Read-side fill code |
| pop_ok | output | 1 | Read-side code valid, low during the flush routine |
| pop_almost_empty | output | 1 | Read-side count is 2 or less, and high on flush completion |

## Verification
A short burst of five words, read back partly and then fully, checks ordering and the exact count codes. It also places the almost-empty edge between two and three entries. A fill from empty to 64 words, checked at 8, 15, 16, 31, 32, 63 and 64 entries, separates each coarse code from its neighbours and tests their priority. One push beyond full and one pop from empty show that the full and empty guards work. A flush issued on a FIFO holding 20 words, with pushes and pops attempted inside the window, measures how long the read side stays invalid and shows that the old content is discarded. A final short burst then shows that the reset pointers still move data correctly.

// File: rtl/xff_pkg.sv
package xff_pkg;

    localparam logic [3:0] CODE_FULL    = 4'b1111;
    localparam logic [3:0] CODE_HALF    = 4'b1110;
    localparam logic [3:0] CODE_QUARTER = 4'b1101;
    localparam logic [3:0] CODE_EIGHT   = 4'b1000;

    // Coarse fill code; highest matching condition wins.
    function automatic logic [3:0] level_code(input logic [31:0] cnt, input logic [31:0] depth);
        logic [3:0] c;
        if (cnt >= depth)            c = CODE_FULL;
        else if (cnt >= depth / 2)   c = CODE_HALF;
        else if (cnt >= depth / 4)   c = CODE_QUARTER;
        else if (cnt >= 32'd8)       c = CODE_EIGHT;
        else                         c = cnt[3:0];
        return c;
    endfunction

endpackage

// File: rtl/xff_sync.sv
module xff_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/xff_mem.sv
module xff_mem #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          wr_en,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge wclk) begin
        if (wr_en) mem_q[waddr] <= wdata;
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n)    rdata_q <= '0;
        else if (rd_en) rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/xff_push_ctrl.sv
module xff_push_ctrl
    import xff_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_en,
    input  logic          push_flush,
    input  logic [PW-1:0] rgray_sync,
    input  logic          ack_sync,
    output logic [PW-1:0] wgray,
    output logic [AW-1:0] waddr,
    output logic          wr_en,
    output logic          req_tog,
    output logic [3:0]    push_flag,
    output logic          push_ok
);
    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] wgray;
        logic          req;
        logic          ack_seen;
        logic          flushing;
    } st_t;

    st_t st_d, st_q;
    logic [PW-1:0] rbin;
    logic [PW-1:0] cnt;
    logic          full;

    always_comb begin
        rbin[PW-1] = rgray_sync[PW-1];
        for (int i = PW - 2; i >= 0; i--) rbin[i] = rbin[i+1] ^ rgray_sync[i];
        cnt   = st_q.wptr - rbin;
        full  = (cnt == PW'(DEPTH));
        wr_en = push_en && !st_q.flushing && !push_flush && !full;

        st_d = st_q;
        if (wr_en) st_d.wptr = st_q.wptr + PW'(1);
        if (!st_q.flushing && push_flush) begin
            st_d.flushing = 1'b1;
            st_d.req      = ~st_q.req;
            st_d.wptr     = '0;
        end else if (st_q.flushing && (ack_sync != st_q.ack_seen)) begin
            st_d.flushing = 1'b0;
            st_d.ack_seen = ack_sync;
        end
        st_d.wgray = st_d.wptr ^ (st_d.wptr >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wgray     = st_q.wgray;
    assign waddr     = st_q.wptr[AW-1:0];
    assign req_tog   = st_q.req;
    assign push_ok   = !st_q.flushing;
    assign push_flag = level_code(32'(cnt), 32'(DEPTH));
endmodule

// File: rtl/xff_pop_ctrl.sv
module xff_pop_ctrl
    import xff_pkg::*;
#(
    parameter int DEPTH        = 64,
    parameter int AE_LIMIT     = 2,
    parameter int FLUSH_CYCLES = 4,
    localparam int AW          = $clog2(DEPTH),
    localparam int PW          = AW + 1,
    localparam int SW          = $clog2(FLUSH_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop_en,
    input  logic [PW-1:0] wgray_sync,
    input  logic          req_sync,
    output logic [PW-1:0] rgray,
    output logic [AW-1:0] raddr,
    output logic          rd_en,
    output logic          ack_tog,
    output logic [3:0]    pop_flag,
    output logic          pop_ok,
    output logic          almost_empty
);
    typedef struct packed {
        logic [PW-1:0] rptr;
        logic [PW-1:0] rgray;
        logic          req_seen;
        logic          ack;
        logic          busy;
        logic [SW-1:0] step;
    } st_t;

    st_t st_d, st_q;
    logic [PW-1:0] wbin;
    logic [PW-1:0] cnt;
    logic          start;

    always_comb begin
        wbin[PW-1] = wgray_sync[PW-1];
        for (int i = PW - 2; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray_sync[i];
        cnt   = wbin - st_q.rptr;
        start = !st_q.busy && (req_sync != st_q.req_seen);
        rd_en = pop_en && !st_q.busy && !start && (cnt != '0);

        st_d = st_q;
        if (rd_en) st_d.rptr = st_q.rptr + PW'(1);
        if (start) begin
            st_d.busy     = 1'b1;
            st_d.step     = '0;
            st_d.req_seen = req_sync;
        end else if (st_q.busy) begin
            if (st_q.step == SW'(FLUSH_CYCLES - 1)) begin
                st_d.busy = 1'b0;
                st_d.rptr = '0;
                st_d.ack  = ~st_q.ack;
            end else begin
                st_d.step = st_q.step + SW'(1);
            end
        end
        st_d.rgray = st_d.rptr ^ (st_d.rptr >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rgray        = st_q.rgray;
    assign raddr        = st_q.rptr[AW-1:0];
    assign ack_tog      = st_q.ack;
    assign pop_ok       = !st_q.busy;
    assign almost_empty = !st_q.busy && (cnt <= PW'(AE_LIMIT));
    assign pop_flag     = level_code(32'(cnt), 32'(DEPTH));
endmodule

// File: rtl/xff_fifo.sv
module xff_fifo #(
    parameter int DW           = 8,
    parameter int DEPTH        = 64,
    parameter int AE_LIMIT     = 2,
    parameter int FLUSH_CYCLES = 4
) (
    input  logic          push_clk,
    input  logic          push_rst_n,
    input  logic          push_en,
    input  logic [DW-1:0] push_data,
    input  logic          push_flush,
    output logic [3:0]    push_flag,
    output logic          push_ok,
    input  logic          pop_clk,
    input  logic          pop_rst_n,
    input  logic          pop_en,
    output logic [DW-1:0] pop_data,
    output logic [3:0]    pop_flag,
    output logic          pop_ok,
    output logic          pop_almost_empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0] wgray, wgray_sync, rgray, rgray_sync;
    logic [AW-1:0] waddr, raddr;
    logic          wr_en, rd_en, req_tog, req_sync, ack_tog, ack_sync;

    xff_push_ctrl #(.DEPTH(DEPTH)) u_push (
        .clk(push_clk), .rst_n(push_rst_n), .push_en(push_en), .push_flush(push_flush),
        .rgray_sync(rgray_sync), .ack_sync(ack_sync), .wgray(wgray), .waddr(waddr),
        .wr_en(wr_en), .req_tog(req_tog), .push_flag(push_flag), .push_ok(push_ok)
    );

    xff_pop_ctrl #(.DEPTH(DEPTH), .AE_LIMIT(AE_LIMIT), .FLUSH_CYCLES(FLUSH_CYCLES)) u_pop (
        .clk(pop_clk), .rst_n(pop_rst_n), .pop_en(pop_en), .wgray_sync(wgray_sync),
        .req_sync(req_sync), .rgray(rgray), .raddr(raddr), .rd_en(rd_en),
        .ack_tog(ack_tog), .pop_flag(pop_flag), .pop_ok(pop_ok), .almost_empty(pop_almost_empty)
    );

    // Pointer and request cross together so both arrive on the same pop edge.
    xff_sync #(.W(PW + 1)) u_to_pop (
        .clk(pop_clk), .rst_n(pop_rst_n), .d({req_tog, wgray}), .q({req_sync, wgray_sync})
    );

    xff_sync #(.W(PW + 1)) u_to_push (
        .clk(push_clk), .rst_n(push_rst_n), .d({ack_tog, rgray}), .q({ack_sync, rgray_sync})
    );

    xff_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .wclk(push_clk), .wr_en(wr_en), .waddr(waddr), .wdata(push_data),
        .rclk(pop_clk), .rrst_n(pop_rst_n), .rd_en(rd_en), .raddr(raddr), .rdata(pop_data)
    );
endmodule

// File: rtl/xff_fifo_chk.sv
module xff_fifo_chk #(
    parameter int DW = 8
) (
    input logic          push_clk,
    input logic          push_rst_n,
    input logic          push_flush,
    input logic [3:0]    push_flag,
    input logic          push_ok,
    input logic          pop_clk,
    input logic          pop_rst_n,
    input logic [DW-1:0] pop_data,
    input logic [3:0]    pop_flag,
    input logic          pop_ok,
    input logic          pop_almost_empty
);
    assert_reserved_code_R4: assert property (@(posedge pop_clk) disable iff (!pop_rst_n)
        pop_ok |-> !(pop_flag inside {[4'b1001:4'b1100]}));

    assert_empty_pop_R6: assert property (@(posedge pop_clk) disable iff (!pop_rst_n)
        (pop_ok && pop_flag == 4'b0000) |=> $stable(pop_data));

    assert_flush_drop_R8: assert property (@(posedge push_clk) disable iff (!push_rst_n)
        $fell(push_ok) |-> $past(push_flush));

    assert_ae_low_R9: assert property (@(posedge pop_clk) disable iff (!pop_rst_n)
        !pop_ok |-> !pop_almost_empty);

    assert_pop_done_R10: assert property (@(posedge pop_clk) disable iff (!pop_rst_n)
        $rose(pop_ok) |-> (pop_flag == 4'b0000 && pop_almost_empty));

    assert_push_done_R10: assert property (@(posedge push_clk) disable iff (!push_rst_n)
        $rose(push_ok) |-> push_flag == 4'b0000);
endmodule

bind xff_fifo xff_fifo_chk #(.DW(DW)) u_chk (
    .push_clk(push_clk), .push_rst_n(push_rst_n), .push_flush(push_flush),
    .push_flag(push_flag), .push_ok(push_ok), .pop_clk(pop_clk), .pop_rst_n(pop_rst_n),
    .pop_data(pop_data), .pop_flag(pop_flag), .pop_ok(pop_ok),
    .pop_almost_empty(pop_almost_empty)
);

// File: tb/xff_fifo_tb.sv
module xff_fifo_tb;
    localparam int PUSH_T = 10;
    localparam int POP_T  = 14;
    localparam int DW     = 8;

    logic          push_clk = 0, pop_clk = 0;
    logic          push_rst_n = 0, pop_rst_n = 0;
    logic          push_en = 0, push_flush = 0, pop_en = 0;
    logic [DW-1:0] push_data = '0;
    logic [3:0]    push_flag, pop_flag;
    logic          push_ok, pop_ok, pop_almost_empty;
    logic [DW-1:0] pop_data;

    int checks = 0, errors = 0;
    logic [DW-1:0] sb[$];

    always #(PUSH_T / 2) push_clk = ~push_clk;
    always #(POP_T / 2)  pop_clk  = ~pop_clk;

    xff_fifo #(.DW(DW)) u_dut (
        .push_clk(push_clk), .push_rst_n(push_rst_n), .push_en(push_en), .push_data(push_data),
        .push_flush(push_flush), .push_flag(push_flag), .push_ok(push_ok),
        .pop_clk(pop_clk), .pop_rst_n(pop_rst_n), .pop_en(pop_en), .pop_data(pop_data),
        .pop_flag(pop_flag), .pop_ok(pop_ok), .pop_almost_empty(pop_almost_empty)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_pop(input int n);
        repeat (n) @(negedge pop_clk);
    endtask

    task automatic wait_push(input int n);
        repeat (n) @(negedge push_clk);
    endtask

    // Driver: one push cycle; accepted words go to the scoreboard.
    task automatic push_word(input logic [DW-1:0] d, input bit keep);
        @(negedge push_clk);
        push_en = 1; push_data = d;
        @(negedge push_clk);
        push_en = 0;
        if (keep) sb.push_back(d);
    endtask

    // Monitor: one pop cycle, compared with the scoreboard head.
    task automatic pop_word(input string req);
        logic [DW-1:0] e;
        @(negedge pop_clk);
        pop_en = 1;
        @(negedge pop_clk);
        pop_en = 0;
        e = (sb.size() > 0) ? sb.pop_front() : 'x;
        chk(req, 32'(pop_data), 32'(e));
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge push_clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [DW-1:0] held;
        int lows, bad_ae;
        #(PUSH_T * 3 + 1);
        push_rst_n = 1; pop_rst_n = 1;
        wait_pop(3);
        chk("R1 push_flag", 32'(push_flag), 0);
        chk("R1 pop_flag", 32'(pop_flag), 0);
        chk("R1 push_ok", 32'(push_ok), 1);
        chk("R1 pop_ok", 32'(pop_ok), 1);
        chk("R1 almost_empty", 32'(pop_almost_empty), 1);

        for (int i = 0; i < 5; i++) push_word(DW'(8'h10 + i), 1);
        wait_pop(6);
        chk("R3 five", 32'(pop_flag), 5);
        chk("R7 five", 32'(pop_almost_empty), 0);
        for (int i = 0; i < 2; i++) pop_word("R2 burst");
        chk("R3 three", 32'(pop_flag), 3);
        chk("R7 three", 32'(pop_almost_empty), 0);
        pop_word("R2 burst");
        chk("R3 two", 32'(pop_flag), 2);
        chk("R7 two", 32'(pop_almost_empty), 1);
        for (int i = 0; i < 2; i++) pop_word("R2 burst");
        chk("R3 empty", 32'(pop_flag), 0);

        held = pop_data;
        @(negedge pop_clk); pop_en = 1;
        @(negedge pop_clk); pop_en = 0;
        wait_pop(1);
        chk("R6 empty pop data", 32'(pop_data), 32'(held));
        chk("R6 empty pop flag", 32'(pop_flag), 0);

        for (int n = 1; n <= 64; n++) begin
            push_word(DW'(n * 3 + 7), 1);
            if (n == 8 || n == 15) begin wait_pop(6); chk("R4 eight", 32'(pop_flag), 4'b1000); end
            if (n == 16 || n == 31) begin wait_pop(6); chk("R4 quarter", 32'(pop_flag), 4'b1101); end
            if (n == 32 || n == 63) begin wait_pop(6); chk("R4 half", 32'(pop_flag), 4'b1110); end
        end
        chk("R5 push full", 32'(push_flag), 4'b1111);
        push_word(8'hEE, 0);
        chk("R5 still full", 32'(push_flag), 4'b1111);
        wait_pop(6);
        chk("R4 full", 32'(pop_flag), 4'b1111);
        for (int i = 0; i < 64; i++) pop_word("R5 R2 drain");
        wait_pop(2);
        chk("R5 drained", 32'(pop_flag), 0);
        wait_push(8);
        chk("R5 push empty", 32'(push_flag), 0);

        for (int i = 0; i < 20; i++) push_word(DW'(8'hA0 + i), 0);
        wait_pop(6);
        chk("R4 twenty", 32'(pop_flag), 4'b1101);
        @(negedge push_clk); push_flush = 1;
        @(negedge push_clk); push_flush = 0;
        chk("R8 push_ok low", 32'(push_ok), 0);
        push_word(8'h55, 0);
        chk("R8 still flushing", 32'(push_ok), 0);
        held = pop_data;
        lows = 0; bad_ae = 0;
        for (int i = 0; i < 25; i++) begin
            @(negedge pop_clk);
            if (!pop_ok) begin
                lows++;
                if (pop_almost_empty) bad_ae++;
            end
            pop_en = !pop_ok;
        end
        pop_en = 0;
        chk("R9 invalid cycles", 32'(lows), 4);
        chk("R9 ae during flush", 32'(bad_ae), 0);
        chk("R9 pops ignored", 32'(pop_data), 32'(held));
        chk("R10 pop_flag", 32'(pop_flag), 0);
        chk("R10 almost_empty", 32'(pop_almost_empty), 1);
        wait_push(20);
        chk("R10 push_ok", 32'(push_ok), 1);
        chk("R10 push_flag", 32'(push_flag), 0);

        for (int i = 0; i < 3; i++) push_word(DW'(8'hC0 + i), 1);
        wait_pop(6);
        chk("R10 refill", 32'(pop_flag), 3);
        for (int i = 0; i < 3; i++) pop_word("R10 R2 after flush");
        chk("R10 empty again", 32'(pop_flag), 0);
        finish_run();
    end
endmodule